// File: doc/BRIEF.md
# Bank-Extended Effective Address Generator

This block forms the 20-bit effective address for a 16-bit processor whose memory space is split into sixteen 64 KiB banks. Each index register is a 16-bit word paired with a 4-bit bank extension, and the block keeps three of them (X, Y, Z) as 20-bit values. The caller presents an addressing-mode code, a 24-bit operand field taken from the instruction, an index select and a 4-bit data bank field. The block returns the address, a valid flag and a flag for the reserved vector region. Index arithmetic runs on the full 20-bit bank:word value, so carries and borrows from the word move into the bank, and results wrap modulo 2^20.

The post-modify mode uses X unchanged as the address. It also presents X plus a signed 8-bit step as a write-back value, and that value is stored when the access is issued. All three registers take their start values from input ports during reset. This lets Z point at a chosen work area from the first instruction, which serves as a fast short-address window. A load port lets the processor overwrite any register. A two-state sequencer (BOOT, RUN) holds the address invalid until the first clock after reset. The only transitions are BOOT to RUN on the first edge with reset low, and any state to BOOT on an edge with reset high.

Top module: `pla_ea_gen`

## Requirements
- R1: While reset is high on a rising edge, X, Y and Z are loaded from `rst_x`, `rst_y` and `rst_z`. The sequencer enters BOOT, and `ea_valid` stays low through reset and the first cycle after reset falls.
- R2: Mode 0 (bank-extended absolute): `ea = {ek, operand[15:0]}`.
- R3: Mode 1 (long absolute): `ea = operand[19:0]`. If `operand[23:20]` is not zero, the access is illegal.
- R4: Mode 2 (short unsigned index): `ea = R + zero_extend(operand[7:0])` mod 2^20. The register R is chosen by `idx_sel` (0 = X, 1 = Y, 2 = Z), and a carry enters the bank field.
- R5: Mode 3 (signed word index): `ea = R + sign_extend(operand[15:0])` mod 2^20, so the result may lie below R.
- R6: Mode 4 (long index): `ea = R + operand[19:0]` mod 2^20, with the operand read as a signed 20-bit value. `operand[23:20]` is ignored in this mode.
- R7: Mode 5 (post-modify X): `ea = X`, and `idx_sel` is ignored. `wb_val = X + sign_extend(operand[7:0])` mod 2^20. When `ea_req` is high, `wb_en` is high and X takes `wb_val` on the next rising edge.
- R8: Mode codes 6 and 7, and `idx_sel = 3` in modes 2 to 4, are illegal. An illegal access drives `ea_valid` low, `ea` to zero and `wb_en` low.
- R9: `ea_vector` is high exactly when `ea_valid` is high and `ea` is below 0x00200.
- R10: With `ld_en` high on a rising edge, the register named by `ld_sel` (0 = X, 1 = Y, 2 = Z) takes `ld_val`. `ld_sel = 3` changes nothing. A load to X takes priority over a post-modify write-back in the same cycle.
- R11: With `ea_req` low, `wb_en` is low and X is not changed by post-modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rst_x | input | 20 | Reset value for X (bank:word) |
| rst_y | input | 20 | Reset value for Y |
| rst_z | input | 20 | Reset value for Z |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Register chosen for load |
| ld_val | input | 20 | Value to load |
| ea_req | input | 1 | Access issued this cycle |
| mode | input | 3 | Addressing-mode code |
| idx_sel | input | 2 | Index register select |
| operand | input | 24 | Instruction operand field |
| ek | input | 4 | Data bank field for mode 0 |
| ea | output | 20 | Effective address |
| ea_valid | output | 1 | Address is legal and usable |
| ea_vector | output | 1 | Address falls in the vector region |
| wb_en | output | 1 | Post-modify write-back of X this cycle |
| wb_val | output | 20 | Post-modify value for X |
| x_q | output | 20 | Current X |
| y_q | output | 20 | Current Y |
| z_q | output | 20 | Current Z |

## Verification
The bench builds the block with its default parameters: a 20-bit address, a 4-bit bank, a 24-bit operand and a vector limit of 0x200. Together these put bank carries, borrows below zero that wrap to the top bank, and both edges of the vector region within a small set of vectors. The Z reset value sits just below a bank boundary, so short unsigned offsets are enough to carry into the bank. The Y reset value sits at 0x00100, so signed offsets can land on 0x00000 or wrap to 0xFFF00.

// File: rtl/pla_pkg.sv
package pla_pkg;

    // addressing-mode codes (decoded by the instruction path)
    localparam logic [2:0] AM_ABS16 = 3'd0;
    localparam logic [2:0] AM_ABS20 = 3'd1;
    localparam logic [2:0] AM_IDX8  = 3'd2;
    localparam logic [2:0] AM_IDX16 = 3'd3;
    localparam logic [2:0] AM_IDX20 = 3'd4;
    localparam logic [2:0] AM_POSTX = 3'd5;

    // register slots
    localparam int REG_X = 0;
    localparam int REG_Y = 1;
    localparam int REG_Z = 2;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/pla_add.sv
module pla_add #(
    parameter int AW = 20
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic [AW-1:0] sum
);
    // modulo 2^AW: any carry out of the bank field is dropped
    assign sum = a + b;
endmodule

// File: rtl/pla_decode.sv
module pla_decode
    import pla_pkg::*;
#(
    parameter int AW   = 20,
    parameter int BW   = 4,
    parameter int OW   = 24,
    parameter int NREG = 3,
    parameter int SW   = 2
) (
    input  logic [2:0]    mode,
    input  logic [SW-1:0] idx_sel,
    input  logic [OW-1:0] operand,
    input  logic [BW-1:0] ek,
    output logic          legal,
    output logic          use_idx,
    output logic          is_post,
    output logic [SW-1:0] sel,
    output logic [AW-1:0] off,
    output logic [AW-1:0] step,
    output logic [AW-1:0] abs_ea
);
    localparam int WW   = AW - BW;   // word width inside a bank
    localparam int SHRT = 8;
    localparam int MID  = 16;

    logic idx_ok;
    assign idx_ok = (int'(idx_sel) < NREG);

    always_comb begin
        legal   = 1'b0;
        use_idx = 1'b0;
        is_post = 1'b0;
        sel     = idx_sel;
        off     = '0;
        abs_ea  = '0;
        step    = {{(AW-SHRT){operand[SHRT-1]}}, operand[SHRT-1:0]};
        unique case (mode)
            AM_ABS16: begin
                legal  = 1'b1;
                abs_ea = {ek, operand[WW-1:0]};
            end
            AM_ABS20: begin
                legal  = (operand[OW-1:AW] == '0);
                abs_ea = operand[AW-1:0];
            end
            AM_IDX8: begin
                legal   = idx_ok;
                use_idx = 1'b1;
                off     = {{(AW-SHRT){1'b0}}, operand[SHRT-1:0]};
            end
            AM_IDX16: begin
                legal   = idx_ok;
                use_idx = 1'b1;
                off     = {{(AW-MID){operand[MID-1]}}, operand[MID-1:0]};
            end
            AM_IDX20: begin
                legal   = idx_ok;
                use_idx = 1'b1;
                off     = operand[AW-1:0];
            end
            AM_POSTX: begin
                legal   = 1'b1;
                use_idx = 1'b1;
                is_post = 1'b1;
                sel     = SW'(REG_X);
            end
            default: begin
                legal = 1'b0;
            end
        endcase
    end

    // R3: a long absolute operand with a non-zero top nibble is never legal
    always_comb begin
        if (mode == AM_ABS20 && operand[OW-1:AW] != '0)
            a_r3_top_nibble: assert (!legal);
    end
endmodule

// File: rtl/pla_regfile.sv
module pla_regfile
    import pla_pkg::*;
#(
    parameter int AW   = 20,
    parameter int NREG = 3,
    parameter int SW   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NREG*AW-1:0] rst_vals,
    input  logic               ld_en,
    input  logic [SW-1:0]      ld_sel,
    input  logic [AW-1:0]      ld_val,
    input  logic               wb_en,
    input  logic [AW-1:0]      wb_val,
    output logic [NREG*AW-1:0] regs_q,
    output logic               run
);
    seq_state_e state_q, state_d;

    // sequencer: state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_BOOT;
        else     state_q <= state_d;
    end

    // sequencer: next state and output
    always_comb begin
        state_d = state_q;
        run     = 1'b0;
        unique case (state_q)
            ST_BOOT: state_d = ST_RUN;
            ST_RUN: begin
                state_d = ST_RUN;
                run     = 1'b1;
            end
            default: state_d = ST_BOOT;
        endcase
    end

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs_q[r*AW +: AW] <= rst_vals[r*AW +: AW];
                else if (ld_en && int'(ld_sel) == r)
                    regs_q[r*AW +: AW] <= ld_val;
                else if (r == REG_X && wb_en)
                    regs_q[r*AW +: AW] <= wb_val;
            end
        end
    endgenerate

    a_r1_reset_load: assert property (@(posedge clk)
        rst |=> regs_q == $past(rst_vals));

    a_r10_load_x: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_sel == SW'(REG_X)) |=> regs_q[REG_X*AW +: AW] == $past(ld_val));

    a_r7_writeback: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !(ld_en && ld_sel == SW'(REG_X))) |=> regs_q[REG_X*AW +: AW] == $past(wb_val));

    a_r11_x_hold: assert property (@(posedge clk) disable iff (rst)
        (!wb_en && !(ld_en && ld_sel == SW'(REG_X))) |=> $stable(regs_q[REG_X*AW +: AW]));
endmodule

// File: rtl/pla_ea_gen.sv
module pla_ea_gen
    import pla_pkg::*;
#(
    parameter int AW      = 20,
    parameter int BW      = 4,
    parameter int OW      = 24,
    parameter int VEC_TOP = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [19:0]   rst_x,
    input  logic [19:0]   rst_y,
    input  logic [19:0]   rst_z,
    input  logic          ld_en,
    input  logic [1:0]    ld_sel,
    input  logic [19:0]   ld_val,
    input  logic          ea_req,
    input  logic [2:0]    mode,
    input  logic [1:0]    idx_sel,
    input  logic [23:0]   operand,
    input  logic [3:0]    ek,
    output logic [19:0]   ea,
    output logic          ea_valid,
    output logic          ea_vector,
    output logic          wb_en,
    output logic [19:0]   wb_val,
    output logic [19:0]   x_q,
    output logic [19:0]   y_q,
    output logic [19:0]   z_q
);
    localparam int NREG = 3;
    localparam int SW   = $clog2(NREG + 1);

    logic [NREG*AW-1:0] regs_q;
    logic               run;
    logic               legal, use_idx, is_post;
    logic [SW-1:0]      sel;
    logic [AW-1:0]      off, step, abs_ea, base, idx_sum, post_sum;
    logic [AW-1:0]      reg_arr [NREG];

    pla_regfile #(.AW(AW), .NREG(NREG), .SW(SW)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .rst_vals ({rst_z, rst_y, rst_x}),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_val   (ld_val),
        .wb_en    (wb_en),
        .wb_val   (wb_val),
        .regs_q   (regs_q),
        .run      (run)
    );

    pla_decode #(.AW(AW), .BW(BW), .OW(OW), .NREG(NREG), .SW(SW)) u_dec (
        .mode    (mode),
        .idx_sel (idx_sel),
        .operand (operand),
        .ek      (ek),
        .legal   (legal),
        .use_idx (use_idx),
        .is_post (is_post),
        .sel     (sel),
        .off     (off),
        .step    (step),
        .abs_ea  (abs_ea)
    );

    generate
        for (genvar r = 0; r < NREG; r++) begin : g_unpack
            assign reg_arr[r] = regs_q[r*AW +: AW];
        end
    endgenerate

    assign base = (int'(sel) < NREG) ? reg_arr[sel] : '0;

    pla_add #(.AW(AW)) u_idx_add (.a(base),             .b(off),  .sum(idx_sum));
    pla_add #(.AW(AW)) u_post_add (.a(reg_arr[REG_X]), .b(step), .sum(post_sum));

    assign ea_valid  = run && legal;
    assign ea        = !ea_valid ? '0 : (use_idx ? idx_sum : abs_ea);
    assign ea_vector = ea_valid && (ea < AW'(VEC_TOP));
    assign wb_en     = ea_valid && is_post && ea_req;
    assign wb_val    = post_sum;

    assign x_q = reg_arr[REG_X];
    assign y_q = reg_arr[REG_Y];
    assign z_q = reg_arr[REG_Z];

    a_r1_boot_invalid: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ea_valid);

    a_r2_bank_field: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && mode == AM_ABS16) |-> ea[AW-1:AW-BW] == ek);

    a_r7_post_addr: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && mode == AM_POSTX) |-> ea == x_q);

    a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        !ea_valid |-> (ea == '0 && !wb_en && !ea_vector));

    a_r9_vector_range: assert property (@(posedge clk) disable iff (rst)
        ea_vector |-> (ea_valid && ea < AW'(VEC_TOP)));

    a_r11_no_req: assert property (@(posedge clk) disable iff (rst)
        !ea_req |-> !wb_en);
endmodule

// File: tb/pla_ea_gen_tb.sv
module pla_ea_gen_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [19:0] rst_x, rst_y, rst_z, ld_val;
    logic        ld_en, ea_req;
    logic [1:0]  ld_sel, idx_sel;
    logic [2:0]  mode;
    logic [23:0] operand;
    logic [3:0]  ek;
    logic [19:0] ea, wb_val, x_q, y_q, z_q;
    logic        ea_valid, ea_vector, wb_en;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pla_ea_gen u_dut (
        .clk(clk), .rst(rst), .rst_x(rst_x), .rst_y(rst_y), .rst_z(rst_z),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val), .ea_req(ea_req),
        .mode(mode), .idx_sel(idx_sel), .operand(operand), .ek(ek),
        .ea(ea), .ea_valid(ea_valid), .ea_vector(ea_vector), .wb_en(wb_en),
        .wb_val(wb_val), .x_q(x_q), .y_q(y_q), .z_q(z_q)
    );

    // {mode, idx_sel, operand, ek, expected ea, valid, vector}
    localparam int NV = 18;
    localparam logic [54:0] VECS [NV] = '{
        {3'd0, 2'd0, 24'h00BEEF, 4'hA, 20'hABEEF, 1'b1, 1'b0},
        {3'd1, 2'd0, 24'h0FEDCB, 4'h0, 20'hFEDCB, 1'b1, 1'b0},
        {3'd1, 2'd0, 24'h1FEDCB, 4'h0, 20'h00000, 1'b0, 1'b0},
        {3'd2, 2'd2, 24'h0000FF, 4'h0, 20'h600EF, 1'b1, 1'b0},
        {3'd2, 2'd2, 24'h000020, 4'h0, 20'h60010, 1'b1, 1'b0},
        {3'd3, 2'd1, 24'h00FF00, 4'h0, 20'h00000, 1'b1, 1'b1},
        {3'd3, 2'd1, 24'h00FE00, 4'h0, 20'hFFF00, 1'b1, 1'b0},
        {3'd3, 2'd0, 24'h007FFF, 4'h0, 20'h1A344, 1'b1, 1'b0},
        {3'd4, 2'd0, 24'hF80000, 4'h0, 20'h92345, 1'b1, 1'b0},
        {3'd4, 2'd1, 24'h0FFF00, 4'h0, 20'h00000, 1'b1, 1'b1},
        {3'd2, 2'd1, 24'h000050, 4'h0, 20'h00150, 1'b1, 1'b1},
        {3'd6, 2'd0, 24'h000000, 4'h0, 20'h00000, 1'b0, 1'b0},
        {3'd7, 2'd0, 24'h000000, 4'h0, 20'h00000, 1'b0, 1'b0},
        {3'd3, 2'd3, 24'h000010, 4'h0, 20'h00000, 1'b0, 1'b0},
        {3'd5, 2'd2, 24'h000080, 4'h0, 20'h12345, 1'b1, 1'b0},
        {3'd0, 2'd0, 24'h0001FF, 4'h0, 20'h001FF, 1'b1, 1'b1},
        {3'd0, 2'd0, 24'h000200, 4'h0, 20'h00200, 1'b1, 1'b0},
        {3'd3, 2'd2, 24'h008000, 4'h0, 20'h57FF0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] m, input logic v);
        if (!v) return "R8";
        case (m)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #3000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual hung expected finish");
        finish_run();
    end

    initial begin
        rst = 1'b1; rst_x = 20'h12345; rst_y = 20'h00100; rst_z = 20'h5FFF0;
        ld_en = 1'b0; ld_sel = 2'd0; ld_val = '0; ea_req = 1'b0;
        mode = 3'd0; idx_sel = 2'd0; operand = '0; ek = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        chk("R1 valid in reset", 32'(ea_valid), 32'd0);
        rst = 1'b0; #2;
        chk("R1 x reset", 32'(x_q), 32'h12345);
        chk("R1 y reset", 32'(y_q), 32'h00100);
        chk("R1 z reset", 32'(z_q), 32'h5FFF0);
        chk("R1 valid first cycle", 32'(ea_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {mode, idx_sel, operand, ek} = VECS[i][54:22];
            #2;
            chk(tag_of(mode, VECS[i][1]), 32'(ea), 32'(VECS[i][21:2]));
            chk("R8 valid", 32'(ea_valid), 32'(VECS[i][1]));
            chk("R9 vector", 32'(ea_vector), 32'(VECS[i][0]));
            chk("R11 wb_en idle", 32'(wb_en), 32'd0);
        end
        chk("R11 x unchanged", 32'(x_q), 32'h12345);

        // R7 post-modify with negative step
        @(negedge clk);
        mode = 3'd5; operand = 24'h0000F0; ea_req = 1'b1; #2;
        chk("R7 ea", 32'(ea), 32'h12345);
        chk("R7 wb_en", 32'(wb_en), 32'd1);
        chk("R7 wb_val", 32'(wb_val), 32'h12335);
        @(negedge clk);
        ea_req = 1'b0; #2;
        chk("R7 x updated", 32'(x_q), 32'h12335);
        chk("R7 ea follows x", 32'(ea), 32'h12335);

        // R10 load X, then R7 carry into bank
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'd0; ld_val = 20'h0FFFC;
        @(negedge clk);
        ld_en = 1'b0; #2;
        chk("R10 load x", 32'(x_q), 32'h0FFFC);
        operand = 24'h000008; ea_req = 1'b1; #2;
        chk("R7 carry wb_val", 32'(wb_val), 32'h10004);
        @(negedge clk);
        ea_req = 1'b0; #2;
        chk("R7 carry x", 32'(x_q), 32'h10004);

        // R10 select 3 ignored
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'd3; ld_val = 20'hAAAAA;
        @(negedge clk);
        ld_en = 1'b0; #2;
        chk("R10 sel3 x", 32'(x_q), 32'h10004);
        chk("R10 sel3 y", 32'(y_q), 32'h00100);
        chk("R10 sel3 z", 32'(z_q), 32'h5FFF0);

        // R10 load Y then use it
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'd1; ld_val = 20'h3FFF0;
        @(negedge clk);
        ld_en = 1'b0; mode = 3'd2; idx_sel = 2'd1; operand = 24'h000011; #2;
        chk("R10 load y", 32'(y_q), 32'h3FFF0);
        chk("R4 carry from loaded y", 32'(ea), 32'h40001);

        // R10 load beats write-back
        @(negedge clk);
        mode = 3'd5; operand = 24'h000001; ea_req = 1'b1;
        ld_en = 1'b1; ld_sel = 2'd0; ld_val = 20'h77777;
        @(negedge clk);
        ld_en = 1'b0; ea_req = 1'b0; #2;
        chk("R10 load priority", 32'(x_q), 32'h77777);

        // R1 reset again mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; #2;
        chk("R1 x reload", 32'(x_q), 32'h12345);
        chk("R1 y reload", 32'(y_q), 32'h00100);
        chk("R1 valid after reload", 32'(ea_valid), 32'd0);
        @(negedge clk); #2;
        chk("R1 valid in run", 32'(ea_valid), 32'd1);

        finish_run();
    end
endmodule